// File: doc/BRIEF.md
# Triggered Memory Stream Mover

This block moves a run of words between a block memory and a ready/valid stream. A single trigger starts the run. In read direction it fetches words from the memory and sends them out on an output stream. In write direction it takes words from an input stream and stores them in the memory. Every run starts at address 0, and the address rises by one for each word moved. No processor has to step the run along.

The memory side is a request port with address, write flag, write data, valid and ready, plus a read-data bus. Read data is available one cycle after the memory accepts a read request. The block registers that data before it presents it on the output stream. The word count is taken from the length input in the cycle the trigger is accepted. A single-cycle done pulse marks the end of each run. The busy output stays high for the whole run, and triggers that arrive during a run have no effect.

Top module: `stream_mem_mover`

## Requirements
- R1: After reset, busy, done, outValid, memValid and inReady are all low.
- R2: A trigger with dirWrite=0 and length L>0 delivers L words on the output stream. Word i is the memory content at address i, for i from 0 to L-1, in rising order. memWrite is low on every memory request of such a run.
- R3: While outValid is high and outReady is low, outValid stays high and outData and outLast keep their values in the next cycle.
- R4: outLast is high exactly when outValid presents the final word (index L-1) of a read run, and is low at all other times.
- R5: The word count is the value on length in the cycle the trigger is accepted. Changing length during a run does not change the number of words moved.
- R6: A trigger with dirWrite=1 and length L>0 stores L words taken from the input stream at addresses 0 to L-1. memWrite is high on these requests, and memWdata carries the accepted input word. Addresses L and above are left unchanged.
- R7: inReady is low whenever busy is low, so no input word is consumed outside a write run. During a write run, inReady is high only while memReady is high.
- R8: done is high for exactly one cycle. That cycle follows the clock edge at which the final word's handshake completes, and busy is low in it. busy only falls together with such a done pulse.
- R9: A trigger that arrives while busy is high is ignored. The current run keeps its direction and its count, and no further run starts afterwards.
- R10: A trigger with length 0 causes no memory request. It produces a done pulse in the cycle after the trigger edge, and busy stays low.
- R11: A memory request holds memValid high and memAddr stable until memReady is seen. Address i is issued for word i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigger | input | 1 | Starts a run when the block is idle |
| dirWrite | input | 1 | Direction taken at trigger: 0 memory to stream, 1 stream to memory |
| length | input | ADDR_W+1 | Number of words, sampled at the trigger |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| memAddr | output | ADDR_W | Memory request address |
| memWrite | output | 1 | Request is a write |
| memWdata | output | DATA_W | Write data |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts the request |
| memRdata | input | DATA_W | Read data, valid one cycle after a read is accepted |
| outValid | output | 1 | Output stream word valid |
| outReady | input | 1 | Output stream sink ready |
| outData | output | DATA_W | Output stream word |
| outLast | output | 1 | Final word of a read run |
| inValid | input | 1 | Input stream word valid |
| inReady | output | 1 | Block accepts the input word |
| inData | input | DATA_W | Input stream word |

## Verification
Several rules hold in every cycle, and the assertions check them continuously. The block stays quiet when idle. Stalled output words and stalled read requests hold their values. inReady is only high while a memory write is being accepted. done only appears with busy low, and busy only falls with done. The remaining properties depend on what happened earlier in the run, and only the bench's scenarios can show them. These are the mapping of word index to address and data, the exact word count, the count latched at the trigger, the trigger ignored during a run, the zero-length run, and the contents left in memory afterwards.

// File: rtl/mover_pkg.sv
package mover_pkg;

  // Sequencer states: one idle state, three read phases, one write phase.
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_RD_OUT  = 3'd3,
    ST_WR      = 3'd4
  } moverState_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic start;    // latch length, clear word index
    logic advance;  // move on to the next word
    logic capture;  // register memory read data
  } moverStrobe_t;

endpackage

// File: rtl/mover_datapath.sv
module mover_datapath
  import mover_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  moverStrobe_t      strobe,
  input  logic [LEN_W-1:0]  lengthIn,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] outData,
  output logic              lastWord,
  output logic              lenZero
);

  logic [LEN_W-1:0]  lenQ;
  logic [LEN_W-1:0]  idxQ;
  logic [DATA_W-1:0] dataQ;
  logic [LEN_W-1:0]  lenMinusOne;

  // Length and word index; the length is sampled only on start.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ <= '0;
      idxQ <= '0;
    end else if (strobe.start) begin
      lenQ <= lengthIn;
      idxQ <= '0;
    end else if (strobe.advance) begin
      idxQ <= idxQ + LEN_W'(1);
    end
  end

  // Read data register in front of the output stream.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
    end else if (strobe.capture) begin
      dataQ <= memRdata;
    end
  end

  assign lenMinusOne = lenQ - LEN_W'(1);
  assign lastWord    = (idxQ == lenMinusOne);
  assign lenZero     = (lengthIn == '0);
  assign memAddr     = idxQ[ADDR_W-1:0];
  assign memWdata    = inData;
  assign outData     = dataQ;

endmodule

// File: rtl/mover_ctrl.sv
module mover_ctrl
  import mover_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         trigger,
  input  logic         dirWrite,
  input  logic         lenZero,
  input  logic         lastWord,
  input  logic         memReady,
  input  logic         inValid,
  input  logic         outReady,
  output moverStrobe_t strobe,
  output logic         memValid,
  output logic         memWrite,
  output logic         inReady,
  output logic         outValid,
  output logic         busy,
  output logic         done
);

  moverState_t stateQ, stateNext;
  logic        doneNext;
  logic        wrHandshake;

  assign wrHandshake = (stateQ == ST_WR) && inValid && memReady;

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    doneNext  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (trigger) begin
          if (lenZero) begin
            doneNext = 1'b1;
          end else begin
            strobe.start = 1'b1;
            stateNext    = dirWrite ? ST_WR : ST_RD_REQ;
          end
        end
      end
      ST_RD_REQ: begin
        if (memReady) stateNext = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        strobe.capture = 1'b1;
        stateNext      = ST_RD_OUT;
      end
      ST_RD_OUT: begin
        if (outReady) begin
          if (lastWord) begin
            doneNext  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strobe.advance = 1'b1;
            stateNext      = ST_RD_REQ;
          end
        end
      end
      ST_WR: begin
        if (wrHandshake) begin
          if (lastWord) begin
            doneNext  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strobe.advance = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      stateQ <= stateNext;
      done   <= doneNext;
    end
  end

  assign memValid = (stateQ == ST_RD_REQ) || ((stateQ == ST_WR) && inValid);
  assign memWrite = (stateQ == ST_WR);
  assign inReady  = (stateQ == ST_WR) && memReady;
  assign outValid = (stateQ == ST_RD_OUT);
  assign busy     = (stateQ != ST_IDLE);

endmodule

// File: rtl/stream_mem_mover.sv
module stream_mem_mover
  import mover_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigger,
  input  logic              dirWrite,
  input  logic [ADDR_W:0]   length,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  output logic              memValid,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData
);

  localparam int LEN_W = ADDR_W + 1;

  moverStrobe_t strobe;
  logic         lastWord;
  logic         lenZero;

  mover_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .trigger  (trigger),
    .dirWrite (dirWrite),
    .lenZero  (lenZero),
    .lastWord (lastWord),
    .memReady (memReady),
    .inValid  (inValid),
    .outReady (outReady),
    .strobe   (strobe),
    .memValid (memValid),
    .memWrite (memWrite),
    .inReady  (inReady),
    .outValid (outValid),
    .busy     (busy),
    .done     (done)
  );

  mover_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lengthIn (length),
    .inData   (inData),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .outData  (outData),
    .lastWord (lastWord),
    .lenZero  (lenZero)
  );

  assign outLast = outValid && lastWord;

endmodule

// File: rtl/stream_mem_mover_chk.sv
module stream_mem_mover_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              memValid,
  input logic              memReady,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              outLast,
  input logic              inValid,
  input logic              inReady
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memValid && !outValid && !inReady));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R7
  in_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (busy && memReady && memWrite && (memValid == inValid)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady && !memWrite) |=> (memValid && $stable(memAddr)));

endmodule

bind stream_mem_mover stream_mem_mover_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .done     (done),
  .memValid (memValid),
  .memReady (memReady),
  .memWrite (memWrite),
  .memAddr  (memAddr),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .outLast  (outLast),
  .inValid  (inValid),
  .inReady  (inReady)
);

// File: tb/stream_mem_mover_tb.sv
`timescale 1ns/1ps
module stream_mem_mover_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 256;
  localparam int RXN = 2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic trigger = 1'b0, dirWrite = 1'b0;
  logic [AW:0] length = '0;
  logic busy, done;
  logic [AW-1:0] memAddr;
  logic memWrite, memValid;
  logic memReady = 1'b0;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata = '0;
  logic outValid, outLast;
  logic outReady = 1'b0;
  logic [DW-1:0] outData;
  logic inValid = 1'b0;
  logic inReady;
  logic [DW-1:0] inData;

  int checks = 0, errors = 0;
  int readyPct = 70;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rxBuf [RXN];
  int srcIdx = 0, memAccCnt = 0, memWrCnt = 0, rxCnt = 0;

  function automatic logic [DW-1:0] srcWord(int k);
    return DW'(k * 40503 + 17) ^ 16'h3c5a;
  endfunction

  function automatic logic [DW-1:0] initWord(int a);
    return DW'(a * 7919 + 3);
  endfunction

  assign inData = srcWord(srcIdx);

  stream_mem_mover #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .trigger(trigger), .dirWrite(dirWrite), .length(length),
    .busy(busy), .done(done), .memAddr(memAddr), .memWrite(memWrite), .memWdata(memWdata),
    .memValid(memValid), .memReady(memReady), .memRdata(memRdata),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast),
    .inValid(inValid), .inReady(inReady), .inData(inData)
  );

  // Memory, sink and source models.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= initWord(i);
      memReady <= 1'b0;
      outReady <= 1'b0;
      inValid  <= 1'b0;
    end else begin
      memReady <= ($urandom % 100) < readyPct;
      outReady <= ($urandom % 100) < readyPct;
      inValid  <= ($urandom % 100) < readyPct;
      if (memValid && memReady) begin
        memAccCnt <= memAccCnt + 1;
        if (memWrite) begin
          mem[memAddr] <= memWdata;
          memWrCnt <= memWrCnt + 1;
        end else begin
          memRdata <= mem[memAddr];
        end
      end
      if (inValid && inReady) srcIdx <= srcIdx + 1;
      if (outValid && outReady) begin
        rxBuf[rxCnt % RXN] <= outData;
        rxCnt <= rxCnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Cycle monitor, sampled at the falling edge.
  bit expDone = 0, prevHold = 0, prevLast = 0, monDir = 0;
  logic [DW-1:0] prevData = '0;
  int monLen = 0, monCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      bit hs;
      check(done == expDone, "R8", "done timing", done, expDone);
      if (prevHold)
        check(outValid && outData == prevData && outLast == prevLast, "R3", "stalled word held",
              outData, prevData);
      if (outValid)
        check(outLast == (monCnt == monLen - 1), "R4", "last flag", outLast, monCnt == monLen - 1);
      if (memValid && memReady)
        check(memAddr == AW'(monCnt) && memWrite == monDir, "R11", "request address",
              memAddr, monCnt);
      if (!busy) check(!inReady, "R7", "inReady while idle", inReady, 0);
      expDone = 0;
      if (trigger && !busy) begin
        monLen = int'(length);
        monDir = dirWrite;
        monCnt = 0;
        if (length == 0) expDone = 1;
      end
      hs = monDir ? (inValid && inReady) : (outValid && outReady);
      if (busy && hs) begin
        if (monCnt == monLen - 1) expDone = 1;
        monCnt++;
      end
      prevHold = outValid && !outReady;
      prevData = outData;
      prevLast = outLast;
    end
  end

  task automatic startXfer(input bit dir, input int len);
    @(posedge clk); #1;
    dirWrite = dir;
    length = (AW + 1)'(len);
    trigger = 1'b1;
    @(posedge clk); #1;
    trigger = 1'b0;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    while (1) begin
      @(negedge clk);
      if (done) break;
      cyc++;
      if (cyc > 20000) begin
        check(0, "R8", "done never seen", 0, 1);
        break;
      end
    end
    @(posedge clk); #1;
  endtask

  task automatic doRead(input int len);
    int rs, cyc, bad;
    rs = rxCnt;
    startXfer(1'b0, len);
    waitDone(cyc);
    check(rxCnt - rs == len, "R2", "read word count", rxCnt - rs, len);
    bad = 0;
    for (int i = 0; i < len; i++)
      if (rxBuf[(rs + i) % RXN] != mem[i]) begin
        if (bad == 0)
          check(0, "R2", "read word value", rxBuf[(rs + i) % RXN], mem[i]);
        bad++;
      end
    if (bad == 0) check(1, "R2", "read word values", 0, 0);
  endtask

  task automatic doWrite(input int len);
    int st, cyc, bad;
    logic [DW-1:0] above;
    st = srcIdx;
    above = (len < DEPTH) ? mem[len] : '0;
    startXfer(1'b1, len);
    waitDone(cyc);
    check(srcIdx - st == len, "R6", "input words consumed", srcIdx - st, len);
    bad = 0;
    for (int i = 0; i < len; i++)
      if (mem[i] != srcWord(st + i)) begin
        if (bad == 0) check(0, "R6", "stored word", mem[i], srcWord(st + i));
        bad++;
      end
    if (bad == 0) check(1, "R6", "stored words", 0, 0);
    if (len < DEPTH) check(mem[len] == above, "R6", "word past run untouched", mem[len], above);
  endtask

  bit finished = 0;

  initial begin
    int cyc, s, acc, wr;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && !outValid && !memValid && !inReady, "R1", "quiet after reset",
          {busy, done, outValid, memValid, inReady}, 0);

    // R7: idle block consumes nothing even with the source valid
    readyPct = 95;
    s = srcIdx;
    repeat (12) @(posedge clk);
    #1 check(srcIdx == s, "R7", "idle consumption", srcIdx - s, 0);

    // R2/R4 directed reads
    readyPct = 100; doRead(1);
    readyPct = 50;  doRead(5);
    // R6 directed write, then read it back
    readyPct = 60;  doWrite(7);
    readyPct = 40;  doRead(9);

    // R10 zero length: done next cycle, no memory traffic
    acc = memAccCnt;
    startXfer(1'b0, 0);
    waitDone(cyc);
    check(cyc == 0, "R10", "done delay", cyc, 0);
    check(memAccCnt == acc && !busy, "R10", "no memory request", memAccCnt - acc, 0);

    // R5 length changed mid-run
    begin
      int rs;
      readyPct = 60;
      rs = rxCnt;
      startXfer(1'b0, 6);
      @(posedge clk); #1 length = 2;
      waitDone(cyc);
      check(rxCnt - rs == 6, "R5", "latched count", rxCnt - rs, 6);
    end

    // R9 trigger while busy ignored
    begin
      int rs;
      readyPct = 60;
      rs = rxCnt;
      wr = memWrCnt;
      startXfer(1'b0, 6);
      repeat (3) @(posedge clk);
      #1; dirWrite = 1'b1; length = 3; trigger = 1'b1;
      @(posedge clk); #1 trigger = 1'b0;
      waitDone(cyc);
      check(rxCnt - rs == 6 && memWrCnt == wr, "R9", "run unchanged", rxCnt - rs, 6);
      repeat (4) @(posedge clk);
      #1 check(!busy, "R9", "no queued run", busy, 0);
    end

    // Full-depth boundary runs
    readyPct = 100; doWrite(DEPTH);
    readyPct = 100; doRead(DEPTH);

    // Random mixed runs
    for (int n = 0; n < 16; n++) begin
      int len;
      len = 1 + int'($urandom % 32);
      readyPct = 30 + int'($urandom % 71);
      if ($urandom % 2) doWrite(len);
      else doRead(len);
    end

    repeat (4) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule